// File: doc/BRIEF.md
# Static LCD Backplane and Segment Phase Driver

This block produces the square-wave backplane and the matching segment waveforms for a static (non-multiplexed) liquid crystal display. A segment that should stay dark is driven in the same phase as the backplane. A segment that should be visible is driven in the opposite phase. Either way the glass sees an alternating drive with no net DC component. The segment pattern comes from a latch elsewhere as an `NSEG`-bit word. The block samples that word only at backplane transitions, so a half-written pattern never shows for part of a phase.

The backplane can be timed from two sources, chosen by a mode input. The internal source is a prescaler running from the system clock. The external source is a clock from outside, which several drivers can share so that all of their backplanes switch together and their outputs can be tied in parallel. In both modes the final stage is a toggle flip-flop. That stage makes the high and low times of the backplane exactly equal, because any imbalance would leave a DC offset on the display. While the external source is in use, the internal divider is held still and an oscillator-enable output is lowered, so an analog oscillator outside the block can be switched off. For a typical glass the divider value is chosen to place the backplane somewhere between about 30 Hz and 150 Hz.

Top module: `lcd_phase_drv`

## Requirements
- R1: While `rst_n` is low, and after it is released, `bp_out` is 0, every bit of `seg_out` is 0 and `osc_en` is 1 until the first backplane toggle or mode change.
- R2: With `use_ext` = 0, every backplane phase lasts exactly `div_sel`+1 system clock cycles for both the high and the low level. `div_sel` = 0 toggles `bp_out` on every clock. `div_sel` is read every cycle, and a phase ends once the internal count reaches or passes it.
- R3: With `use_ext` = 1, `ext_bp_clk` passes through `SYNC_STAGES` synchronizer flops and one edge register. Each rising edge of `ext_bp_clk` toggles `bp_out` on the (`SYNC_STAGES`+1)-th clock edge after it is first sampled. The high and low times of `bp_out` both equal the external period, whatever the external duty cycle.
- R4: `seg_out[i]` equals latched segment bit i XOR `bp_out`: a latched 1 drives the line in antiphase to the backplane (visible), and a latched 0 drives it in phase (dark).
- R5: `seg_word` is captured only on the clock edge where `bp_out` toggles. Between toggles, a change of `seg_word` leaves `seg_out` unchanged, and `seg_out` never changes without `bp_out` changing on the same edge.
- R6: Selecting the external source drives `osc_en` to 0 on the next clock edge and holds the prescaler at zero. After a return to `use_ext` = 0, `osc_en` is 1 on the next edge, and the first backplane toggle falls on the (`div_sel`+1)-th clock edge sampling `use_ext` = 0.
- R7: In internal mode `ext_bp_clk` has no effect on any output. In external mode `div_sel` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_ext | input | 1 | Backplane source: 0 = internal prescaler, 1 = external clock |
| ext_bp_clk | input | 1 | External backplane timing clock, asynchronous to `clk` |
| div_sel | input | DIV_W | Internal phase length minus one, in system clock cycles |
| seg_word | input | NSEG | Latched segment pattern, 1 = segment visible |
| osc_en | output | 1 | Enable for an external analog oscillator, low in external mode |
| bp_out | output | 1 | Backplane square wave |
| seg_out | output | NSEG | Segment drive lines |

## Verification
The bench builds the block with its defaults: `NSEG` = 32, `DIV_W` = 16, `SYNC_STAGES` = 2 and rising-edge-only external timing. Because the divider value is a port, small `div_sel` values such as 0, 3, 5 and 20 keep each backplane phase a few cycles long. Many complete phases, mode changes and mid-phase pattern updates therefore fit in a short run. With the full 32-bit segment word, mixed patterns show the in-phase and antiphase drive on every line at once.

// File: rtl/lcd_phase_pkg.sv
package lcd_phase_pkg;

   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_EXTERNAL = 1'b1
   } bp_src_e;

   // Number of clock edges from a sampled external rising edge to the backplane toggle
   function automatic int ext_latency(input int stages);
      return stages + 1;
   endfunction

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);

   localparam logic [DIV_W-1:0] CNT_ZERO = '0;
   localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (cnt >= limit);
   assign tick = !stop && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CNT_ZERO;
      end else if (stop || wrap) begin
         cnt <= CNT_ZERO;
      end else begin
         cnt <= cnt + CNT_ONE;
      end
   end

   // R6: divider is frozen at zero while the external source is in use
   a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (cnt == CNT_ZERO))
      else $error("prescaler not held while stopped");

   // R2: a phase end restarts the count
   a_r2_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == CNT_ZERO))
      else $error("prescaler did not restart after tick");

endmodule

// File: rtl/lcd_ext_edge.sv
module lcd_ext_edge #(
   parameter int SYNC_STAGES    = 2,
   parameter bit EXT_BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   output logic tick
);

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= ext_in;
            end
         end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   generate
      if (EXT_BOTH_EDGES) begin : g_both
         assign tick = sync_q[LAST] ^ prev_q;
      end else begin : g_rise
         assign tick = sync_q[LAST] & ~prev_q;

         // R3: one external rising edge yields exactly one timing pulse
         a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick)
            else $error("external edge produced a stretched pulse");
      end
   endgenerate

endmodule

// File: rtl/lcd_bp_toggle.sv
module lcd_bp_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic bp
);

   logic bp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bp_q <= 1'b0;
      else if (tick) bp_q <= ~bp_q;
   end

   assign bp = bp_q;

   // R2: each timing pulse flips the backplane
   a_r2_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (bp_q != $past(bp_q)))
      else $error("backplane missed a toggle");

   // R5: no timing pulse, no backplane movement
   a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(bp_q))
      else $error("backplane moved without a tick");

endmodule

// File: rtl/lcd_seg_phase.sv
module lcd_seg_phase #(
   parameter int NSEG = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [NSEG-1:0] word,
   input  logic            bp,
   output logic [NSEG-1:0] seg
);

   logic [NSEG-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_q <= '0;
      else if (load) lat_q <= word;
   end

   generate
      for (genvar i = 0; i < NSEG; i++) begin : g_line
         assign seg[i] = lat_q[i] ^ bp;
      end
   endgenerate

   // R5: segment lines move only together with a backplane transition
   a_r5_seg_with_bp: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seg) |-> !$stable(bp))
      else $error("segment changed mid-phase");

endmodule

// File: rtl/lcd_phase_drv.sv
module lcd_phase_drv #(
   parameter int NSEG           = 32,
   parameter int DIV_W          = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit EXT_BOTH_EDGES = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_ext,
   input  logic             ext_bp_clk,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [NSEG-1:0]  seg_word,
   output logic             osc_en,
   output logic             bp_out,
   output logic [NSEG-1:0]  seg_out
);

   import lcd_phase_pkg::*;

   generate
      if (NSEG < 1)        begin : g_bad_nseg  $error("NSEG must be at least 1");        end
      if (DIV_W < 1)       begin : g_bad_divw  $error("DIV_W must be at least 1");       end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   bp_src_e src;
   logic    int_tick;
   logic    ext_tick;
   logic    phase_tick;
   logic    bp;
   logic    osc_en_q;

   assign src = bp_src_e'(use_ext);

   lcd_prescaler #(
      .DIV_W (DIV_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .stop  (src == SRC_EXTERNAL),
      .limit (div_sel),
      .tick  (int_tick)
   );

   lcd_ext_edge #(
      .SYNC_STAGES    (SYNC_STAGES),
      .EXT_BOTH_EDGES (EXT_BOTH_EDGES)
   ) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .ext_in (ext_bp_clk),
      .tick   (ext_tick)
   );

   always_comb begin
      unique case (src)
         SRC_EXTERNAL: phase_tick = ext_tick;
         default:      phase_tick = int_tick;
      endcase
   end

   lcd_bp_toggle u_tff (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (phase_tick),
      .bp    (bp)
   );

   lcd_seg_phase #(
      .NSEG (NSEG)
   ) u_seg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (phase_tick),
      .word  (seg_word),
      .bp    (bp),
      .seg   (seg_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_en_q <= 1'b1;
      else        osc_en_q <= (src == SRC_INTERNAL);
   end

   assign osc_en = osc_en_q;
   assign bp_out = bp;

   // R7: in internal mode the external timing path never reaches the backplane
   a_r7_ext_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_ext && !int_tick) |=> $stable(bp_out))
      else $error("external clock leaked into internal mode");

endmodule

// File: tb/lcd_phase_drv_tb.sv
module lcd_phase_drv_tb;

   localparam int NSEG  = 32;
   localparam int DIV_W = 16;
   localparam int SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             use_ext = 1'b0;
   logic             ext_bp_clk = 1'b0;
   logic [DIV_W-1:0] div_sel = '0;
   logic [NSEG-1:0]  seg_word = '0;
   logic             osc_en;
   logic             bp_out;
   logic [NSEG-1:0]  seg_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   lcd_phase_drv #(
      .NSEG        (NSEG),
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .use_ext    (use_ext),
      .ext_bp_clk (ext_bp_clk),
      .div_sel    (div_sel),
      .seg_word   (seg_word),
      .osc_en     (osc_en),
      .bp_out     (bp_out),
      .seg_out    (seg_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int              m_cnt;
   bit              m_bp;
   bit              m_osc;
   logic [NSEG-1:0] m_lat;
   bit              m_hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_bp = 0; m_osc = 1; m_lat = '0;
         m_hist = {};
         for (int k = 0; k <= SYNC; k++) m_hist.push_back(1'b0);
      end else begin
         bit rise;
         bit tk;
         rise = m_hist[SYNC-1] && !m_hist[SYNC];
         tk   = use_ext ? rise : (m_cnt >= int'(div_sel));
         if (use_ext || m_cnt >= int'(div_sel)) m_cnt = 0;
         else m_cnt = m_cnt + 1;
         m_hist.push_front(ext_bp_clk);
         void'(m_hist.pop_back());
         if (tk) begin
            m_bp  = !m_bp;
            m_lat = seg_word;
         end
         m_osc = !use_ext;
      end
   end

   // Every-cycle comparison, sampled after the edge has settled
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(use_ext ? "R3" : "R2", "bp_out vs model", 64'(bp_out), 64'(m_bp));
         chk("R4", "seg_out vs model", 64'(seg_out), 64'(m_lat ^ {NSEG{m_bp}}));
         chk("R6", "osc_en vs model", 64'(osc_en), 64'(m_osc));
      end
   end

   task automatic wait_bp_edge();
      logic prev;
      prev = bp_out;
      for (int k = 0; k < 2000; k++) begin
         @(posedge clk); #1;
         if (bp_out !== prev) return;
      end
   endtask

   task automatic measure_level(input logic lvl, output int len);
      len = 0;
      for (int k = 0; k < 2000 && bp_out === lvl; k++) begin @(posedge clk); #1; end
      for (int k = 0; k < 2000 && bp_out !== lvl; k++) begin @(posedge clk); #1; end
      while (bp_out === lvl && len < 2000) begin
         len++;
         @(posedge clk); #1;
      end
   endtask

   task automatic drive_ext(input int hi, input int lo, input int periods);
      for (int p = 0; p < periods; p++) begin
         @(negedge clk) ext_bp_clk = 1'b1;
         repeat (hi) @(negedge clk);
         ext_bp_clk = 1'b0;
         repeat (lo - 1) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int hi, lo, n;
      logic [NSEG-1:0] held;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "bp_out in reset", 64'(bp_out), 64'd0);
      chk("R1", "seg_out in reset", 64'(seg_out), 64'd0);
      chk("R1", "osc_en in reset", 64'(osc_en), 64'd1);
      seg_word = 32'hA5A5_0F0F;
      div_sel  = 16'd3;
      @(negedge clk) rst_n = 1'b1;

      // R2: internal, div 3 -> 4-cycle phases
      measure_level(1'b1, hi);
      measure_level(1'b0, lo);
      chk("R2", "internal high length div=3", 64'(hi), 64'd4);
      chk("R2", "internal low length div=3", 64'(lo), 64'd4);

      // R4: phase relation of the latched pattern
      wait_bp_edge();
      chk("R4", "seg_out antiphase pattern", 64'(seg_out), 64'(32'hA5A5_0F0F ^ {NSEG{bp_out}}));

      // R5: mid-phase update has no effect until the next toggle
      @(negedge clk) div_sel = 16'd20;
      wait_bp_edge();
      held = seg_out;
      @(negedge clk) seg_word = 32'h1234_FFFF;
      repeat (4) @(posedge clk);
      #1;
      chk("R5", "seg_out held mid-phase", 64'(seg_out), 64'(held));
      wait_bp_edge();
      chk("R5", "new word after toggle", 64'(seg_out), 64'(32'h1234_FFFF ^ {NSEG{bp_out}}));

      // R7: external clock ignored in internal mode
      fork
         drive_ext(1, 2, 40);
         begin
            measure_level(1'b1, hi);
         end
      join
      chk("R7", "internal phase with ext activity", 64'(hi), 64'd21);

      // R6: switch to external source
      @(negedge clk) use_ext = 1'b1;
      @(posedge clk); #1;
      chk("R6", "osc_en low in external mode", 64'(osc_en), 64'd0);

      // R3: symmetric and asymmetric external clocks both give 10/10
      fork
         drive_ext(5, 5, 12);
         begin
            measure_level(1'b1, hi);
            measure_level(1'b0, lo);
         end
      join
      chk("R3", "ext 5/5 high length", 64'(hi), 64'd10);
      chk("R3", "ext 5/5 low length", 64'(lo), 64'd10);
      seg_word = 32'hFFFF_0000;
      fork
         drive_ext(2, 8, 12);
         begin
            measure_level(1'b1, hi);
            measure_level(1'b0, lo);
         end
         begin
            repeat (7) @(negedge clk);
            div_sel = 16'd0;   // R7: no effect in external mode
         end
      join
      chk("R3", "ext 2/8 high length", 64'(hi), 64'd10);
      chk("R3", "ext 2/8 low length", 64'(lo), 64'd10);

      // R3: latency from external rise to toggle
      repeat (6) @(negedge clk);
      held = seg_out;
      hi = int'(bp_out);
      @(negedge clk) ext_bp_clk = 1'b1;
      n = 0;
      for (int k = 0; k < 20 && int'(bp_out) == hi; k++) begin @(posedge clk); #1; n++; end
      chk("R3", "ext rise to toggle edges", 64'(n), 64'(SYNC + 1));
      @(negedge clk) ext_bp_clk = 1'b0;
      repeat (4) @(negedge clk);

      // R6: return to internal; first toggle on edge div+1
      div_sel = 16'd5;
      hi = int'(bp_out);
      @(negedge clk) use_ext = 1'b0;
      n = 0;
      for (int k = 0; k < 40 && int'(bp_out) == hi; k++) begin @(posedge clk); #1; n++; end
      chk("R6", "first internal toggle after return", 64'(n), 64'd6);
      chk("R6", "osc_en high again", 64'(osc_en), 64'd1);

      // R2: div 0 toggles every cycle
      @(negedge clk) div_sel = 16'd0;
      measure_level(1'b1, hi);
      measure_level(1'b0, lo);
      chk("R2", "div=0 high length", 64'(hi), 64'd1);
      chk("R2", "div=0 low length", 64'(lo), 64'd1);

      // R1: reset mid-run
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "bp_out after mid reset", 64'(bp_out), 64'd0);
      chk("R1", "seg_out after mid reset", 64'(seg_out), 64'd0);
      chk("R1", "osc_en after mid reset", 64'(osc_en), 64'd1);
      @(negedge clk) rst_n = 1'b1;
      repeat (10) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule